// File: doc/BRIEF.md
# TMDS Pixel Symbol Encoder

This block encodes one colour channel of a digital video link. On every clock it takes an 8-bit colour value and emits one 10-bit symbol. The symbol has few bit transitions and helps keep the serial line DC-balanced. A DVI transmitter uses three instances, one each for red, green and blue, and each instance has its own disparity accumulator.

While the data-enable strobe is high, the symbol comes from a two-stage encoder with a disparity input and output between the stages. The first stage chains the input bits through XOR or XNOR gates and appends a flag that records which gate was used. The second stage decides whether to invert the low byte. It bases that decision on the signed disparity of the low byte alone and on the running disparity carried over from earlier symbols, and it returns the updated running disparity.

While data-enable is low, one of four fixed control symbols is sent and the running disparity is cleared. The next active region therefore starts from a balanced state. Every symbol is registered, so the output follows the inputs after one clock.

Top module: `tmds_symbol_encoder`

## Requirements
- R1: While reset is asserted, and after it until the first data is captured, the output is the control symbol 10'b1101010100 and the running disparity is zero.
- R2: The first stage uses the XNOR chain when the input has more than four ones, or exactly four ones with input bit 0 equal to 0; otherwise it uses the XOR chain. Intermediate bit 8 is 1 for XOR and 0 for XNOR.
- R3: Intermediate bit 0 equals input bit 0. Each intermediate bit i from 1 to 7 is intermediate bit i-1 combined with input bit i by the chosen gate. As a result the low byte never has more than three transitions.
- R4: When the running disparity is zero, or the low intermediate byte has as many ones as zeros, the low byte is inverted exactly when intermediate bit 8 is 0.
- R5: In every other case the low byte is inverted exactly when the running disparity and the byte disparity (ones minus zeros) have the same sign.
- R6: Output bit 9 is the inversion flag, output bit 8 is intermediate bit 8, and output bits 7:0 are the intermediate low byte, complemented when the flag is set.
- R7: The running disparity is updated as follows.
  - In the case of R4, the byte disparity is subtracted when the byte is inverted and added otherwise.
  - When inverted otherwise, it becomes rd + 2*bit8 - cnt.
  - When not inverted otherwise, it becomes rd - 2*(1-bit8) + cnt.
  - It always equals the summed disparity of the 10-bit data symbols sent since the last blanking cycle.
- R8: With data-enable low, the control bits {c1,c0} choose the symbol: 00 gives 1101010100, 01 gives 0010101011, 10 gives 0101010100, and 11 gives 1010101011 (bit 9 first).
- R9: Any clock with data-enable low clears the running disparity, so the first data symbol after blanking is encoded as if starting from zero.
- R10: The output changes only at a clock edge and shows the symbol for the inputs captured at that edge, which is one cycle of latency.
- R11: The running disparity, and with it the cumulative disparity of the data symbols since blanking, stays within -8 to +8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| de_i | input | 1 | Data enable: high for pixel data, low for control symbols |
| data_i | input | 8 | Colour value for this channel |
| ctl_i | input | 2 | Control bits {c1,c0} used while de_i is low |
| sym_o | output | 10 | Registered 10-bit symbol |

## Verification
The cycle in which data-enable rises is where two functions meet. In that cycle the encoder must emit a data symbol and, in the same evaluation, use the accumulator that the blanking logic cleared on the edge before. To provoke this, the bench first leaves the accumulator well away from zero with a run of all-zero pixels. It then inserts a single blanking cycle and sends an all-zero pixel straight after. The check passes only if that pixel comes out as the symbol for zero running disparity (10'b0100000000) and not the inverted form a stale accumulator would produce. Long random streams with scattered single-cycle blanks repeat this meeting many times. At each one the reference model's symbol is compared, and the cumulative disparity of the data symbols is checked against its bound.

// File: rtl/tmds_enc_pkg.sv
package tmds_enc_pkg;

  // Width of one colour component and of the resulting line symbol.
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned SYM_W  = BYTE_W + 2;
  localparam int unsigned CTL_W  = 2;

  typedef logic [SYM_W-1:0] sym_t;

  // Blanking symbols, selected by {c1,c0}.
  localparam sym_t CTL_SYM_00 = 10'b1101010100;
  localparam sym_t CTL_SYM_01 = 10'b0010101011;
  localparam sym_t CTL_SYM_10 = 10'b0101010100;
  localparam sym_t CTL_SYM_11 = 10'b1010101011;

endpackage

// File: rtl/tmds_ctrl_symbol.sv
module tmds_ctrl_symbol
  import tmds_enc_pkg::*;
(
  input  logic [CTL_W-1:0] ctl_i,
  output sym_t             sym_o
);

  always_comb begin
    unique case (ctl_i)
      2'b00:   sym_o = CTL_SYM_00;
      2'b01:   sym_o = CTL_SYM_01;
      2'b10:   sym_o = CTL_SYM_10;
      default: sym_o = CTL_SYM_11;
    endcase
  end

endmodule

// File: rtl/tmds_transition_min.sv
// First stage: transition-minimising chain over the input byte.
module tmds_transition_min #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W:0]   qm_o
);

  localparam int unsigned HALF  = BYTE_W / 2;
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0]  ones;
  logic              use_xnor;
  logic [BYTE_W-1:0] link;
  logic [CNT_W-1:0]  edges;

  // Population count of the input byte.
  always_comb begin
    ones = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      ones = ones + CNT_W'(data_i[i]);
    end
  end

  // Gate choice: XNOR for heavy bytes, ties broken by bit 0.
  assign use_xnor = (ones > CNT_W'(HALF)) ||
                    ((ones == CNT_W'(HALF)) && !data_i[0]);

  assign link[0] = data_i[0];

  generate
    for (genvar g = 1; g < BYTE_W; g++) begin : g_chain
      // XNOR is XOR with an extra inversion.
      assign link[g] = link[g-1] ^ data_i[g] ^ use_xnor;
    end
  endgenerate

  assign qm_o = {~use_xnor, link};

  // Transition count of the chained byte, used only by the check below.
  always_comb begin
    edges = '0;
    for (int i = 1; i < BYTE_W; i++) begin
      edges = edges + CNT_W'(link[i] ^ link[i-1]);
    end
  end

  always_comb begin
    if (!$isunknown(data_i)) begin
      AST_FEW_TRANSITIONS: assert (edges <= CNT_W'(HALF - 1)) // R3
        else $error("chained byte has too many transitions");
    end
  end

endmodule

// File: rtl/tmds_dc_balance.sv
// Second stage: conditional inversion and running-disparity update.
module tmds_dc_balance #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned RD_W   = 5
) (
  input  logic [BYTE_W:0]          qm_i,
  input  logic signed [RD_W-1:0]   rd_i,
  output logic [BYTE_W+1:0]        sym_o,
  output logic signed [RD_W-1:0]   rd_o
);

  localparam logic signed [RD_W-1:0] SPAN = RD_W'(BYTE_W);
  localparam logic signed [RD_W-1:0] TWO  = RD_W'(2);
  localparam logic signed [RD_W-1:0] NIL  = '0;

  logic [RD_W-1:0]        ones;
  logic signed [RD_W-1:0] cnt;
  logic                   bal_zero;
  logic                   same_sign;
  logic                   invert;
  int                     sym_ones;

  // Signed disparity of the low intermediate byte: ones minus zeros.
  always_comb begin
    ones = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      ones = ones + RD_W'(qm_i[i]);
    end
    cnt = $signed(ones + ones) - SPAN;
  end

  assign bal_zero  = (rd_i == NIL) || (cnt == NIL);
  assign same_sign = (rd_i[RD_W-1] == cnt[RD_W-1]);
  assign invert    = bal_zero ? ~qm_i[BYTE_W] : same_sign;

  assign sym_o = {invert, qm_i[BYTE_W],
                  invert ? ~qm_i[BYTE_W-1:0] : qm_i[BYTE_W-1:0]};

  always_comb begin
    if (bal_zero) begin
      rd_o = invert ? (rd_i - cnt) : (rd_i + cnt);
    end else if (invert) begin
      rd_o = rd_i - cnt + (qm_i[BYTE_W] ? TWO : NIL);
    end else begin
      rd_o = rd_i + cnt - (qm_i[BYTE_W] ? NIL : TWO);
    end
  end

  // Step in disparity must match the symbol actually emitted.
  always_comb begin
    sym_ones = 0;
    for (int i = 0; i < BYTE_W + 2; i++) begin
      sym_ones = sym_ones + int'(sym_o[i]);
    end
    if (!$isunknown({qm_i, rd_i})) begin
      AST_STEP_MATCHES_SYMBOL: assert (2 * sym_ones - int'(BYTE_W + 2) == int'(rd_o) - int'(rd_i)) // R7
        else $error("disparity step differs from emitted symbol");
    end
  end

endmodule

// File: rtl/tmds_symbol_encoder.sv
module tmds_symbol_encoder
  import tmds_enc_pkg::*;
#(
  parameter int unsigned RD_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output logic [SYM_W-1:0]  sym_o
);

  localparam logic signed [RD_W-1:0] RD_LIMIT = RD_W'(BYTE_W);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe[1];

  // Datapath.
  logic [BYTE_W:0]        qm;
  sym_t                   data_sym;
  sym_t                   ctl_sym;
  logic signed [RD_W-1:0] rd_q;
  logic signed [RD_W-1:0] rd_next_enc;
  logic signed [RD_W-1:0] rd_d;
  sym_t                   sym_q;
  sym_t                   sym_d;

  tmds_transition_min #(
    .BYTE_W (BYTE_W)
  ) u_stage_min (
    .data_i (data_i),
    .qm_o   (qm)
  );

  tmds_dc_balance #(
    .BYTE_W (BYTE_W),
    .RD_W   (RD_W)
  ) u_stage_bal (
    .qm_i  (qm),
    .rd_i  (rd_q),
    .sym_o (data_sym),
    .rd_o  (rd_next_enc)
  );

  tmds_ctrl_symbol u_ctrl (
    .ctl_i (ctl_i),
    .sym_o (ctl_sym)
  );

  // Next state.
  always_comb begin
    if (de_i) begin
      sym_d = data_sym;
      rd_d  = rd_next_enc;
    end else begin
      sym_d = ctl_sym;
      rd_d  = '0;
    end
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sym_q <= CTL_SYM_00;
      rd_q  <= '0;
    end else begin
      sym_q <= sym_d;
      rd_q  <= rd_d;
    end
  end

  assign sym_o = sym_q;

  AST_BLANK_CLEARS_RD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !de_i |=> (rd_q == '0)) // R9
    else $error("running disparity not cleared after blanking");

  AST_RD_BOUNDED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_q <= RD_LIMIT) && (rd_q >= -RD_LIMIT)) // R11
    else $error("running disparity out of range");

  AST_RD_EVEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_q[0] == 1'b0) // R7
    else $error("running disparity is odd");

endmodule

// File: tb/tmds_symbol_encoder_bench.sv
`timescale 1ns/1ps
module tmds_symbol_encoder_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       de_i;
  logic [7:0] data_i;
  logic [1:0] ctl_i;
  logic [9:0] sym_o;

  always #2.5 clk = ~clk;

  tmds_symbol_encoder u_tmds_symbol_encoder (
    .clk    (clk),
    .rst_n  (rst_n),
    .de_i   (de_i),
    .data_i (data_i),
    .ctl_i  (ctl_i),
    .sym_o  (sym_o)
  );

  typedef struct {
    logic [9:0] sym;
    bit         is_data;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   model_rd = 0;
  int   stream_disp = 0;
  bit   done = 0;

  // Behavioural encoder built from the requirements.
  function automatic void model(input logic [7:0] d, input int rd_in,
                                output logic [9:0] s, output int rd_out);
    int n1 = $countones(d);
    bit xn = (n1 > 4) || (n1 == 4 && d[0] == 1'b0);
    logic [8:0] m;
    int cnt;
    bit inv;
    m[0] = d[0];
    for (int i = 1; i < 8; i++) m[i] = xn ? ~(m[i-1] ^ d[i]) : (m[i-1] ^ d[i]);
    m[8] = !xn;
    cnt = 2 * $countones(m[7:0]) - 8;
    if (rd_in == 0 || cnt == 0) begin
      inv = !m[8];
      rd_out = inv ? rd_in - cnt : rd_in + cnt;
    end else begin
      inv = (rd_in > 0) == (cnt > 0);
      if (inv) rd_out = rd_in + (m[8] ? 2 : 0) - cnt;
      else     rd_out = rd_in - (m[8] ? 0 : 2) + cnt;
    end
    s = {inv, m[8], inv ? ~m[7:0] : m[7:0]};
  endfunction

  function automatic logic [9:0] ctl_code(input logic [1:0] c);
    case (c)
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Driver: apply one cycle of input and queue the expected symbol.
  task automatic drive(input bit de, input logic [7:0] d,
                       input logic [1:0] c, input string req);
    exp_t it;
    int nrd;
    @(negedge clk);
    de_i = de; data_i = d; ctl_i = c;
    if (de) begin
      model(d, model_rd, it.sym, nrd);
      model_rd = nrd;
    end else begin
      it.sym = ctl_code(c);
      model_rd = 0;
    end
    it.is_data = de;
    it.req = req;
    q.push_back(it);
  endtask

  // Monitor: one cycle after capture, compare and track stream disparity.
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(sym_o === it.sym, it.req, sym_o, it.sym);
        if (it.is_data) begin
          stream_disp += 2 * $countones(sym_o) - 10;
          checks++;
          if (stream_disp > 8 || stream_disp < -8) begin
            errors++;
            $display("FAIL R11: cumulative disparity actual %0d expected within -8..8", stream_disp);
          end
        end else begin
          stream_disp = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; de_i = 1'b0; data_i = '0; ctl_i = '0;
    repeat (3) @(negedge clk);
    check(sym_o === 10'b1101010100, "R1", sym_o, 10'b1101010100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sym_o === 10'b1101010100, "R1", sym_o, 10'b1101010100);

    // R8: all four control symbols
    drive(1'b0, 8'h00, 2'b00, "R8");
    drive(1'b0, 8'h00, 2'b01, "R8");
    drive(1'b0, 8'h00, 2'b10, "R8");
    drive(1'b0, 8'h00, 2'b11, "R8");

    // R4 then R5: zero byte from rd 0, then with rd negative
    drive(1'b1, 8'h00, 2'b00, "R4");
    drive(1'b1, 8'h00, 2'b00, "R5");
    drive(1'b1, 8'hFF, 2'b00, "R2");
    drive(1'b1, 8'h01, 2'b00, "R3");
    drive(1'b1, 8'h55, 2'b00, "R6");
    drive(1'b1, 8'h0F, 2'b00, "R4");
    drive(1'b1, 8'hF0, 2'b00, "R2");

    // R9: leave rd non-zero, one blank, then a zero byte
    drive(1'b1, 8'h00, 2'b00, "R7");
    drive(1'b0, 8'h00, 2'b01, "R8");
    drive(1'b1, 8'h00, 2'b00, "R9");
    drive(1'b1, 8'h00, 2'b00, "R9");

    // R10: back-to-back distinct values, one per cycle
    drive(1'b1, 8'hA5, 2'b00, "R10");
    drive(1'b1, 8'h3C, 2'b00, "R10");
    drive(1'b1, 8'hC3, 2'b00, "R10");

    // R7: long unbroken data run
    for (int n = 0; n < 1500; n++) drive(1'b1, 8'($urandom), 2'b00, "R7");

    // R6/R9: random data with scattered blanking
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(15) == 0) drive(1'b0, 8'($urandom), 2'($urandom), "R9");
      else drive(1'b1, 8'($urandom), 2'($urandom), "R6");
    end

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule